// File: doc/BRIEF.md
# Granule Tag Store Engine

This block keeps a four-bit lock tag for every 16-byte granule of a small on-chip memory, next to the 128-bit contents of that granule. Commands come in through a valid/ready port. They can read a tag back into the key field of a pointer, set tags with or without clearing the data, write a tag and data in one step, read the data of a granule, or move the tags of a whole 256-byte block packed into one 64-bit word.

The engine handles one command at a time and touches one granule per clock. A command therefore takes one, two or sixteen memory cycles, depending on how many granules it spans. Every command, refused or not, ends with a single-cycle response that carries read data and an error flag. The bulk forms are kept for privileged callers. When the privilege input is zero, a bulk command is answered with an error and touches nothing.

Top module: `gts_engine`

## Requirements
- R1: While reset is held and after it is released, `cmd_ready` is 1 and `rsp_valid` is 0.
- R2: A command is taken when `cmd_valid` and `cmd_ready` are both 1. From the next cycle `cmd_ready` stays 0 until the response cycle. `rsp_valid` is high for exactly one cycle per command, and responses come in command order.
- R3: Opcode 0 returns `cmd_ptr` with bits 59:56 replaced by the stored tag of the granule that holds byte address `cmd_ptr[11:0]` (aligned down to 16 bytes). The upper 64 response bits are zero.
- R4: Opcode 1 writes `cmd_ptr[59:56]` as the tag of the addressed granule and leaves its data unchanged.
- R5: Opcode 2 writes `cmd_ptr[59:56]` as the tag of the addressed granule and sets its data to zero.
- R6: For opcodes 1 and 2, `cmd_pair`=1 applies the update to both granules of the 32-byte span that holds the address (aligned down to 32 bytes). For all other opcodes `cmd_pair` is ignored.
- R7: Opcode 3 writes `cmd_ptr[59:56]` as the tag and the 128-bit `cmd_wdata` as the data of one granule.
- R8: Opcode 7 returns the 128-bit data of the addressed granule.
- R9: Opcode 4 returns, in response bits 63:0, the tags of the 16 granules of the 256-byte block holding the address. The granule at block offset i sits in bits 4i+3:4i.
- R10: Opcode 5 writes the 16 tags of the block from `cmd_wdata[63:0]`, using the packing of R9, and leaves the data unchanged. Opcode 6 does the same and also zeroes the data of all 16 granules.
- R11: A bulk opcode (4, 5, 6) with `cmd_priv`=0 gets `rsp_err`=1 and `rsp_data`=0 and changes no tag or data. Any other command gets `rsp_err`=0.
- R12: With N the number of granules touched (1, 2 or 16, and 0 for a refused command), `rsp_valid` is high in the cycle after the (N+1)-th rising edge that follows the accepting edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Engine idle, command will be taken |
| cmd_op | input | 3 | Opcode (0..7, see requirements) |
| cmd_priv | input | 2 | Caller privilege level, 0 is the lowest |
| cmd_pair | input | 1 | Two-granule form for opcodes 1 and 2 |
| cmd_ptr | input | 64 | Pointer: byte address in bits 11:0, key tag in bits 59:56 |
| cmd_wdata | input | 128 | Granule data (opcode 3) or packed tags (opcodes 5, 6) |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_err | output | 1 | Command refused |
| rsp_data | output | 128 | Read result, zero for writes |

## Verification
Tags and data live only inside the memories, so a wrong write address, wrong write enable or wrong packing slot is invisible until a later read of that granule. It then shows up as a wrong key in a tag read, a wrong nibble in a bulk read, or stale or non-zero data in a data read. Random traffic across a 4 KiB space lets such reads follow writes to the same granules within a few commands. Sequencer faults, such as a wrong span length or a dropped refusal, show up immediately in the response latency and error flag of the command itself.

// File: rtl/gts_pkg.sv
package gts_pkg;

  typedef enum logic [2:0] {
    OP_TAG_RD  = 3'd0,
    OP_TAG_SET = 3'd1,
    OP_TAG_CLR = 3'd2,
    OP_TAG_DAT = 3'd3,
    OP_BLK_RD  = 3'd4,
    OP_BLK_WR  = 3'd5,
    OP_BLK_CLR = 3'd6,
    OP_DAT_RD  = 3'd7
  } gts_op_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_RUN   = 2'd1,
    ST_DRAIN = 2'd2
  } gts_state_e;

  function automatic logic is_bulk(gts_op_e op);
    return (op == OP_BLK_RD) || (op == OP_BLK_WR) || (op == OP_BLK_CLR);
  endfunction

endpackage

// File: rtl/gts_ram.sv
module gts_ram #(
  parameter int WIDTH = 4,
  parameter int DEPTH = 256,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             we,
  input  logic [AW-1:0]    addr,
  input  logic [WIDTH-1:0] wdata,
  output logic [WIDTH-1:0] rdata
);

  logic [WIDTH-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wdata;
    rdata <= mem[addr];
  end

endmodule

// File: rtl/gts_ctrl.sv
module gts_ctrl import gts_pkg::*; #(
  parameter int ADDR_W    = 12,
  parameter int PTR_W     = 64,
  parameter int DATA_W    = 128,
  parameter int TAG_W     = 4,
  parameter int KEY_LSB   = 56,
  parameter int BLK_GRANS = 16,
  parameter int PRIV_W    = 2,
  localparam int GRAN_LSB = $clog2(DATA_W / 8),
  localparam int GIDX_W   = ADDR_W - GRAN_LSB,
  localparam int SLOT_W   = $clog2(BLK_GRANS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic [2:0]        cmd_op,
  input  logic [PRIV_W-1:0] cmd_priv,
  input  logic              cmd_pair,
  input  logic [PTR_W-1:0]  cmd_ptr,
  input  logic [DATA_W-1:0] cmd_wdata,
  output logic [GIDX_W-1:0] mem_addr,
  output logic              tag_we,
  output logic [TAG_W-1:0]  tag_wdata,
  output logic              data_we,
  output logic [DATA_W-1:0] data_wdata,
  output logic              rd_valid,
  output logic [SLOT_W-1:0] rd_slot,
  output logic              done,
  output logic              refused,
  output gts_op_e           op,
  output logic [PTR_W-1:0]  ptr
);

  gts_state_e        state_q;
  gts_op_e           op_q, op_in;
  logic [PTR_W-1:0]  ptr_q;
  logic [DATA_W-1:0] wdata_q;
  logic [GIDX_W-1:0] base_q, base_in, g_in;
  logic [SLOT_W-1:0] idx_q, last_q, last_in;
  logic              refused_q, in_refuse, accept, in_pair;

  assign op_in     = gts_op_e'(cmd_op);
  assign cmd_ready = (state_q == ST_IDLE);
  assign accept    = cmd_valid && cmd_ready;
  assign g_in      = cmd_ptr[ADDR_W-1:GRAN_LSB];
  assign in_refuse = is_bulk(op_in) && (cmd_priv == '0);
  assign in_pair   = cmd_pair && ((op_in == OP_TAG_SET) || (op_in == OP_TAG_CLR));

  // span decode: bulk block, 32-byte pair, or single granule
  always_comb begin
    if (is_bulk(op_in)) begin
      base_in = g_in & ~GIDX_W'(BLK_GRANS - 1);
      last_in = SLOT_W'(BLK_GRANS - 1);
    end else if (in_pair) begin
      base_in = g_in & ~GIDX_W'(1);
      last_in = SLOT_W'(1);
    end else begin
      base_in = g_in;
      last_in = '0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= ST_IDLE;
      op_q      <= OP_TAG_RD;
      ptr_q     <= '0;
      wdata_q   <= '0;
      base_q    <= '0;
      last_q    <= '0;
      idx_q     <= '0;
      refused_q <= 1'b0;
      rd_valid  <= 1'b0;
      rd_slot   <= '0;
    end else begin
      rd_valid <= (state_q == ST_RUN) &&
                  ((op_q == OP_TAG_RD) || (op_q == OP_BLK_RD) || (op_q == OP_DAT_RD));
      rd_slot  <= idx_q;
      case (state_q)
        ST_IDLE: if (accept) begin
          op_q      <= op_in;
          ptr_q     <= cmd_ptr;
          wdata_q   <= cmd_wdata;
          base_q    <= base_in;
          last_q    <= last_in;
          idx_q     <= '0;
          refused_q <= in_refuse;
          state_q   <= in_refuse ? ST_DRAIN : ST_RUN;
        end
        ST_RUN: begin
          idx_q <= idx_q + SLOT_W'(1);
          if (idx_q == last_q) state_q <= ST_DRAIN;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign mem_addr = base_q | GIDX_W'(idx_q);

  always_comb begin
    tag_we     = 1'b0;
    data_we    = 1'b0;
    tag_wdata  = ptr_q[KEY_LSB +: TAG_W];
    data_wdata = '0;
    if (state_q == ST_RUN) begin
      case (op_q)
        OP_TAG_SET: tag_we = 1'b1;
        OP_TAG_CLR: begin tag_we = 1'b1; data_we = 1'b1; end
        OP_TAG_DAT: begin tag_we = 1'b1; data_we = 1'b1; data_wdata = wdata_q; end
        OP_BLK_WR:  begin tag_we = 1'b1; tag_wdata = wdata_q[TAG_W*int'(idx_q) +: TAG_W]; end
        OP_BLK_CLR: begin
          tag_we    = 1'b1;
          data_we   = 1'b1;
          tag_wdata = wdata_q[TAG_W*int'(idx_q) +: TAG_W];
        end
        default: ;
      endcase
    end
  end

  assign done    = (state_q == ST_DRAIN);
  assign refused = refused_q;
  assign op      = op_q;
  assign ptr     = ptr_q;

  // R2: a taken command makes the engine busy on the next cycle
  p_busy_after_accept_r2: assert property (@(posedge clk) disable iff (rst)
    accept |=> !cmd_ready);

  // R11: a refused bulk command never reaches a memory write
  p_refuse_no_write_r11: assert property (@(posedge clk) disable iff (rst)
    (accept && in_refuse) |=> !(tag_we || data_we));

  // R10: plain bulk tag write never disturbs granule data
  p_blk_wr_keeps_data_r10: assert property (@(posedge clk) disable iff (rst)
    (tag_we && op_q == OP_BLK_WR) |-> !data_we);

endmodule

// File: rtl/gts_collect.sv
module gts_collect import gts_pkg::*; #(
  parameter int PTR_W     = 64,
  parameter int DATA_W    = 128,
  parameter int TAG_W     = 4,
  parameter int KEY_LSB   = 56,
  parameter int BLK_GRANS = 16,
  localparam int SLOT_W   = $clog2(BLK_GRANS),
  localparam int PACK_W   = TAG_W * BLK_GRANS
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_valid,
  input  logic [SLOT_W-1:0] rd_slot,
  input  logic [TAG_W-1:0]  tag_rdata,
  input  logic [DATA_W-1:0] data_rdata,
  input  logic              done,
  input  logic              refused,
  input  gts_op_e           op,
  input  logic [PTR_W-1:0]  ptr,
  output logic              rsp_valid,
  output logic              rsp_err,
  output logic [DATA_W-1:0] rsp_data
);

  logic [PACK_W-1:0] acc_q, acc_nx;
  logic [DATA_W-1:0] dat_q, dat_nx, rsp_nx;
  logic [PTR_W-1:0]  keyed;

  always_comb begin
    acc_nx = acc_q;
    dat_nx = dat_q;
    if (rd_valid) begin
      acc_nx[TAG_W*int'(rd_slot) +: TAG_W] = tag_rdata;
      dat_nx = data_rdata;
    end
    keyed = ptr;
    keyed[KEY_LSB +: TAG_W] = acc_nx[TAG_W-1:0];
    case (op)
      OP_TAG_RD: rsp_nx = DATA_W'(keyed);
      OP_DAT_RD: rsp_nx = dat_nx;
      OP_BLK_RD: rsp_nx = DATA_W'(acc_nx);
      default:   rsp_nx = '0;
    endcase
    if (refused) rsp_nx = '0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_q     <= '0;
      dat_q     <= '0;
      rsp_valid <= 1'b0;
      rsp_err   <= 1'b0;
      rsp_data  <= '0;
    end else begin
      acc_q     <= acc_nx;
      dat_q     <= dat_nx;
      rsp_valid <= done;
      rsp_err   <= done && refused;
      if (done) rsp_data <= rsp_nx;
    end
  end

  // R2: each response strobe lasts exactly one cycle
  p_single_strobe_r2: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |=> !rsp_valid);

  // R11: an error response carries no data
  p_err_no_data_r11: assert property (@(posedge clk) disable iff (rst)
    rsp_err |-> (rsp_valid && rsp_data == '0));

endmodule

// File: rtl/gts_engine.sv
module gts_engine import gts_pkg::*; #(
  parameter int ADDR_W    = 12,
  parameter int PTR_W     = 64,
  parameter int DATA_W    = 128,
  parameter int TAG_W     = 4,
  parameter int KEY_LSB   = 56,
  parameter int BLK_GRANS = 16,
  parameter int PRIV_W    = 2,
  localparam int GRAN_LSB = $clog2(DATA_W / 8),
  localparam int GIDX_W   = ADDR_W - GRAN_LSB,
  localparam int NGRANS   = 1 << GIDX_W,
  localparam int SLOT_W   = $clog2(BLK_GRANS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic [2:0]        cmd_op,
  input  logic [PRIV_W-1:0] cmd_priv,
  input  logic              cmd_pair,
  input  logic [PTR_W-1:0]  cmd_ptr,
  input  logic [DATA_W-1:0] cmd_wdata,
  output logic              rsp_valid,
  output logic              rsp_err,
  output logic [DATA_W-1:0] rsp_data
);

  logic [GIDX_W-1:0] mem_addr;
  logic              tag_we, data_we, rd_valid, done, refused;
  logic [TAG_W-1:0]  tag_wdata, tag_rdata;
  logic [DATA_W-1:0] data_wdata, data_rdata;
  logic [SLOT_W-1:0] rd_slot;
  gts_op_e           op;
  logic [PTR_W-1:0]  ptr;

  gts_ctrl #(
    .ADDR_W(ADDR_W), .PTR_W(PTR_W), .DATA_W(DATA_W), .TAG_W(TAG_W),
    .KEY_LSB(KEY_LSB), .BLK_GRANS(BLK_GRANS), .PRIV_W(PRIV_W)
  ) u_ctrl (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_op(cmd_op), .cmd_priv(cmd_priv), .cmd_pair(cmd_pair),
    .cmd_ptr(cmd_ptr), .cmd_wdata(cmd_wdata), .mem_addr(mem_addr),
    .tag_we(tag_we), .tag_wdata(tag_wdata), .data_we(data_we),
    .data_wdata(data_wdata), .rd_valid(rd_valid), .rd_slot(rd_slot),
    .done(done), .refused(refused), .op(op), .ptr(ptr)
  );

  gts_ram #(.WIDTH(TAG_W), .DEPTH(NGRANS)) u_tag_ram (
    .clk(clk), .we(tag_we), .addr(mem_addr), .wdata(tag_wdata), .rdata(tag_rdata)
  );

  gts_ram #(.WIDTH(DATA_W), .DEPTH(NGRANS)) u_data_ram (
    .clk(clk), .we(data_we), .addr(mem_addr), .wdata(data_wdata), .rdata(data_rdata)
  );

  gts_collect #(
    .PTR_W(PTR_W), .DATA_W(DATA_W), .TAG_W(TAG_W),
    .KEY_LSB(KEY_LSB), .BLK_GRANS(BLK_GRANS)
  ) u_collect (
    .clk(clk), .rst(rst), .rd_valid(rd_valid), .rd_slot(rd_slot),
    .tag_rdata(tag_rdata), .data_rdata(data_rdata), .done(done),
    .refused(refused), .op(op), .ptr(ptr), .rsp_valid(rsp_valid),
    .rsp_err(rsp_err), .rsp_data(rsp_data)
  );

  logic take_unpriv_bulk;
  assign take_unpriv_bulk = cmd_valid && cmd_ready &&
                            is_bulk(gts_op_e'(cmd_op)) && (cmd_priv == '0);

  // R12: a refused command answers at the second edge after acceptance
  p_refuse_latency_r12: assert property (@(posedge clk) disable iff (rst)
    take_unpriv_bulk |=> ##1 (rsp_valid && rsp_err));

  // R2: the response cycle finds the engine idle again
  p_ready_in_rsp_r2: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> cmd_ready);

endmodule

// File: tb/gts_engine_test.sv
module gts_engine_test;
  localparam int CLK_PERIOD = 10;
  localparam int NG = 256;

  logic         clk, rst, cmd_valid, cmd_ready, cmd_pair, rsp_valid, rsp_err;
  logic [2:0]   cmd_op;
  logic [1:0]   cmd_priv;
  logic [63:0]  cmd_ptr;
  logic [127:0] cmd_wdata, rsp_data;

  gts_engine uut (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_op(cmd_op), .cmd_priv(cmd_priv), .cmd_pair(cmd_pair),
    .cmd_ptr(cmd_ptr), .cmd_wdata(cmd_wdata), .rsp_valid(rsp_valid),
    .rsp_err(rsp_err), .rsp_data(rsp_data)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  int n_vec = 0;
  int n_bad = 0;
  logic [3:0]   m_tag  [NG];
  logic [127:0] m_data [NG];

  task automatic check(string req, logic [127:0] act, logic [127:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic run_cmd(logic [2:0] op, logic [1:0] priv, logic pair,
                         logic [63:0] ptr, logic [127:0] wd);
    int g, base, n, k;
    logic blk, refuse;
    logic [127:0] exp;
    logic [63:0] kp;
    string req;
    g      = int'(ptr[11:4]);
    blk    = (op >= 3'd4) && (op <= 3'd6);
    refuse = blk && (priv == 2'd0);
    base = g; n = 1;
    if (blk) begin base = g & ~15; n = 16; end
    else if (pair && (op == 3'd1 || op == 3'd2)) begin base = g & ~1; n = 2; end
    exp = '0;
    case (op)
      3'd0: begin kp = ptr; kp[59:56] = m_tag[g]; exp = {64'd0, kp}; req = "R3"; end
      3'd1: req = (n == 2) ? "R6" : "R4";
      3'd2: req = (n == 2) ? "R6" : "R5";
      3'd3: req = "R7";
      3'd4: begin
        for (int i = 0; i < 16; i++) exp[4*i +: 4] = m_tag[base + i];
        req = "R9";
      end
      3'd7: begin exp = m_data[g]; req = "R8"; end
      default: req = "R10";
    endcase
    if (refuse) begin exp = '0; n = 0; req = "R11"; end

    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = op; cmd_priv = priv; cmd_pair = pair;
    cmd_ptr = ptr; cmd_wdata = wd;
    @(posedge clk);
    @(negedge clk);
    cmd_valid = 1'b0;
    check("R2 busy", {127'd0, cmd_ready}, 128'd0);
    k = 0;
    while (!rsp_valid && k < 40) begin
      @(posedge clk); k++; @(negedge clk);
    end
    check("R12 latency", 128'(k), 128'(n + 1));
    check({req, " err"}, {127'd0, rsp_err}, {127'd0, refuse});
    check({req, " data"}, rsp_data, exp);
    @(posedge clk); @(negedge clk);
    check("R2 strobe", {126'd0, rsp_valid, cmd_ready}, 128'd1);

    if (!refuse) begin
      for (int i = 0; i < n; i++) begin
        case (op)
          3'd1: m_tag[base + i] = ptr[59:56];
          3'd2: begin m_tag[base + i] = ptr[59:56]; m_data[base + i] = '0; end
          3'd3: begin m_tag[base + i] = ptr[59:56]; m_data[base + i] = wd; end
          3'd5: m_tag[base + i] = wd[4*i +: 4];
          3'd6: begin m_tag[base + i] = wd[4*i +: 4]; m_data[base + i] = '0; end
          default: ;
        endcase
      end
    end
  endtask

  function automatic logic [63:0] kptr(logic [3:0] tag, logic [11:0] a);
    return {4'hA, tag, 44'h0_1234_5678_9AB, a};
  endfunction

  initial begin
    #(CLK_PERIOD * 200000);
    n_bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd7741));
    rst = 1'b1; cmd_valid = 1'b0; cmd_op = '0; cmd_priv = '0; cmd_pair = 1'b0;
    cmd_ptr = '0; cmd_wdata = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1 ready in reset", {127'd0, cmd_ready}, 128'd1);
    check("R1 no rsp in reset", {127'd0, rsp_valid}, 128'd0);
    rst = 1'b0;
    @(posedge clk); @(negedge clk);
    check("R1 ready after reset", {126'd0, cmd_ready, rsp_valid}, 128'd2);

    // fill every block with known tags and zero data (R10 bulk clear)
    for (int b = 0; b < 16; b++)
      run_cmd(3'd6, 2'd1, 1'b0, {52'd0, 12'(b * 256)}, {64'd0, {$urandom, $urandom}});

    // R7 then R4: tag-only set must keep the data written before
    run_cmd(3'd3, 2'd0, 1'b1, kptr(4'h5, 12'h120), 128'hDEAD_BEEF_0123_4567_89AB_CDEF_F00D_CAFE);
    run_cmd(3'd1, 2'd0, 1'b0, kptr(4'h9, 12'h12F), '0);
    run_cmd(3'd7, 2'd0, 1'b0, kptr(4'h0, 12'h128), '0);
    run_cmd(3'd0, 2'd0, 1'b0, kptr(4'h3, 12'h125), '0);
    // R6: pair at the odd granule of a 32-byte span
    run_cmd(3'd3, 2'd0, 1'b0, kptr(4'h1, 12'h340), {4{32'h5A5A_A5A5}});
    run_cmd(3'd2, 2'd3, 1'b1, kptr(4'hC, 12'h35B), '0);
    run_cmd(3'd7, 2'd0, 1'b0, kptr(4'h0, 12'h340), '0);
    run_cmd(3'd0, 2'd0, 1'b0, kptr(4'h0, 12'h344), '0);
    run_cmd(3'd0, 2'd0, 1'b0, kptr(4'h0, 12'h350), '0);
    // R11: unprivileged bulk write and clear must leave the block intact
    run_cmd(3'd5, 2'd0, 1'b0, kptr(4'h0, 12'h300), {64'd0, 64'hFFFF_FFFF_FFFF_FFFF});
    run_cmd(3'd6, 2'd0, 1'b0, kptr(4'h0, 12'h300), '0);
    run_cmd(3'd4, 2'd0, 1'b0, kptr(4'h0, 12'h300), '0);
    run_cmd(3'd4, 2'd2, 1'b0, kptr(4'h0, 12'h3A7), '0);
    run_cmd(3'd7, 2'd0, 1'b0, kptr(4'h0, 12'h340), '0);
    // R10: privileged bulk write keeps data
    run_cmd(3'd5, 2'd1, 1'b1, kptr(4'h0, 12'h3F0), {64'd0, 64'h0123_4567_89AB_CDEF});
    run_cmd(3'd4, 2'd1, 1'b0, kptr(4'h0, 12'h300), '0);
    run_cmd(3'd7, 2'd1, 1'b0, kptr(4'h0, 12'h340), '0);

    for (int t = 0; t < 500; t++)
      run_cmd(3'($urandom_range(0, 7)), 2'($urandom_range(0, 3)), 1'($urandom),
              {$urandom, $urandom},
              {$urandom, $urandom, $urandom, $urandom});

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule